// File: doc/BRIEF.md
# Flash Status Polling Matcher

This block repeatedly reads a flash device's status through a serial command engine and stops waiting once the returned value satisfies a masked comparison. Each poll is one read request. The engine answers it with one response carrying 1 to 4 status bytes. The block keeps only the configured number of low bytes and compares them with a match value, using only the bits that a mask selects. A match can mean that every selected bit agrees with its match bit, or that at least one selected bit agrees.

Between polls the block waits a programmable number of clock cycles. When auto-stop is enabled, polling ends on the first match. When it is disabled, polling continues and each match sets the flag again, until an abort arrives or the enable input falls. The outputs are a sticky match flag (with an interrupt gated by an enable), the last status value read, and a busy indication.

Both engine interfaces use valid/ready. A request is held valid until the engine accepts it. The engine may stall a request by keeping ready low for any number of cycles. The block accepts a response only while it is waiting for one. Control and status pins are plain levels or single-cycle pulses. The configuration inputs must be held stable while busy is high.

Top module: `status_poll_matcher`

## Requirements
- R1: After reset, busy, match_flag, irq, rd_req_valid and rd_rsp_ready are 0, and last_status is 0.
- R2: A start pulse taken while enable is 1 (and abort is 0) raises busy and rd_req_valid in the next cycle. A start pulse while enable is 0 is ignored, and busy stays 0.
- R3: Once raised, rd_req_valid stays 1 until a cycle in which rd_req_ready is 1. rd_rsp_ready is 1 only after that acceptance, while a response is awaited.
- R4: cfg_size selects how many status bytes are kept: code 0, 1, 2 or 3 keeps 1, 2, 3 or 4 bytes. last_status takes the kept low bytes of rd_rsp_data, with the higher bytes zero, in the cycle after the response handshake.
- R5: With cfg_or_mode = 0 (all-bits mode), a poll matches when every bit selected by cfg_mask equals the corresponding bit of cfg_match. An empty selection therefore matches.
- R6: With cfg_or_mode = 1 (any-bit mode), a poll matches when at least one selected bit equals its match bit. An empty selection never matches.
- R7: Bits of cfg_mask and cfg_match above the kept byte count have no effect on the match result.
- R8: After a response that does not end polling, rd_req_valid stays 0 for exactly cfg_gap + 1 cycles and then rises again.
- R9: With cfg_auto_stop = 1, a matching response drops busy in the next cycle, and no further request is issued.
- R10: With cfg_auto_stop = 0, polling continues after a match. match_flag is set by every matching response and stays set through later non-matching responses.
- R11: An abort pulse, or enable falling to 0, returns the block to idle: busy is 0 in the next cycle. last_status keeps its value.
- R12: match_clr clears match_flag in the next cycle, unless a matching response is accepted in the same cycle, in which case the flag is set. irq equals match_flag AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 forces idle |
| start | input | 1 | Pulse that begins polling |
| abort | input | 1 | Pulse that stops polling |
| cfg_mask | input | 32 | Selects the bits that take part in the comparison |
| cfg_match | input | 32 | Value compared against |
| cfg_size | input | 2 | Kept byte count minus one |
| cfg_or_mode | input | 1 | 0 = all-bits match, 1 = any-bit match |
| cfg_auto_stop | input | 1 | Stop polling on the first match |
| cfg_gap | input | 16 | Idle cycles between polls, minus one |
| irq_en | input | 1 | Interrupt enable for the match flag |
| match_clr | input | 1 | Pulse that clears match_flag |
| rd_req_valid | output | 1 | Status read request valid |
| rd_req_ready | input | 1 | Engine accepts the request |
| rd_rsp_valid | input | 1 | Engine response valid |
| rd_rsp_ready | output | 1 | Block accepts the response |
| rd_rsp_data | input | 32 | Status bytes, byte 0 in the low bits |
| busy | output | 1 | Polling in progress |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |
| last_status | output | 32 | Last status value read |

## Verification
Busy and rd_req_valid follow a start pulse by one clock. match_flag, last_status and an auto-stop drop of busy follow the response handshake by one clock, and an abort or loss of enable clears busy one clock later. The bench drives every input on the falling edge and samples at the falling edge that follows the handshake edge. The inter-poll gap is measured by counting falling edges with rd_req_valid low, starting right after the response, which gives cfg_gap + 1 exactly.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_GAP  = 2'd3
  } spm_state_e;
endpackage

// File: rtl/spm_compare.sv
module spm_compare #(
  parameter int MAX_BYTES = 4,
  localparam int DATA_W = 8 * MAX_BYTES,
  localparam int SIZE_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] match,
  input  logic [SIZE_W-1:0] size,
  input  logic              or_mode,
  output logic [DATA_W-1:0] kept,
  output logic              hit
);
  logic [DATA_W-1:0] lane_keep;
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] agree;

  // lane i is kept when its index is within the configured byte count
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    assign lane_keep[8*i +: 8] = (SIZE_W'(i) <= size) ? 8'hFF : 8'h00;
  end

  assign kept  = data & lane_keep;
  assign sel   = mask & lane_keep;
  assign agree = ~(data ^ match);

  always_comb begin
    if (or_mode) hit = |(agree & sel);
    else         hit = ((~agree) & sel) == '0;
  end
endmodule

// File: rtl/spm_gap_timer.sv
module spm_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R8: the gap window shrinks by exactly one per running cycle
  assert_gap_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/spm_sequencer.sv
module spm_sequencer
  import spm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic abort,
  input  logic auto_stop,
  input  logic hit,
  input  logic gap_done,
  output logic rd_req_valid,
  input  logic rd_req_ready,
  input  logic rd_rsp_valid,
  output logic rd_rsp_ready,
  output logic capture,
  output logic gap_load,
  output logic gap_run,
  output logic busy
);
  spm_state_e state_q, state_d;
  logic halt;

  assign halt         = abort | ~enable;
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_rsp_ready = (state_q == ST_RSP) && !halt;
  assign capture      = rd_rsp_ready && rd_rsp_valid;
  assign gap_load     = capture;
  assign gap_run      = (state_q == ST_GAP);
  assign busy         = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)        state_d = ST_REQ;
      ST_REQ:  if (rd_req_ready) state_d = ST_RSP;
      ST_RSP:  if (capture)      state_d = (hit && auto_stop) ? ST_IDLE : ST_GAP;
      ST_GAP:  if (gap_done)     state_d = ST_REQ;
      default:                   state_d = ST_IDLE;
    endcase
    if (halt) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !halt) |=> rd_req_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !rd_rsp_ready));
  assert_auto_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && hit && auto_stop) |=> !busy);
  assert_halt_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !busy);
endmodule

// File: rtl/status_poll_matcher.sv
module status_poll_matcher #(
  parameter int MAX_BYTES = 4,
  parameter int GAP_W     = 16,
  localparam int DATA_W   = 8 * MAX_BYTES,
  localparam int SIZE_W   = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [DATA_W-1:0] cfg_match,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_or_mode,
  input  logic              cfg_auto_stop,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              irq_en,
  input  logic              match_clr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              busy,
  output logic              match_flag,
  output logic              irq,
  output logic [DATA_W-1:0] last_status
);
  logic              hit, capture, gap_load, gap_run, gap_done;
  logic [DATA_W-1:0] kept;

  spm_compare #(.MAX_BYTES(MAX_BYTES)) u_cmp (
    .data(rd_rsp_data), .mask(cfg_mask), .match(cfg_match),
    .size(cfg_size), .or_mode(cfg_or_mode), .kept(kept), .hit(hit)
  );

  spm_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(cfg_gap),
    .run(gap_run), .done(gap_done)
  );

  spm_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .abort(abort),
    .auto_stop(cfg_auto_stop), .hit(hit), .gap_done(gap_done),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .capture(capture), .gap_load(gap_load), .gap_run(gap_run), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_status <= '0;
      match_flag  <= 1'b0;
    end else begin
      if (capture) last_status <= kept;
      if (capture && hit) match_flag <= 1'b1;
      else if (match_clr) match_flag <= 1'b0;
    end
  end

  assign irq = match_flag & irq_en;

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);
  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (match_clr && !(capture && hit)) |=> !match_flag);
  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(last_status));
  always_comb begin
    if (rst_n) assert_irq_gated_R12: assert (!irq || match_flag);
  end
endmodule

// File: tb/status_poll_matcher_tb.sv
module status_poll_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, start = 1'b0, abort = 1'b0;
  logic [31:0] cfg_mask = '0, cfg_match = '0;
  logic [1:0]  cfg_size = '0;
  logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b0;
  logic [15:0] cfg_gap = '0;
  logic        irq_en = 1'b0, match_clr = 1'b0;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic        rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic        busy, match_flag, irq;
  logic [31:0] last_status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  status_poll_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .abort(abort),
    .cfg_mask(cfg_mask), .cfg_match(cfg_match), .cfg_size(cfg_size),
    .cfg_or_mode(cfg_or_mode), .cfg_auto_stop(cfg_auto_stop), .cfg_gap(cfg_gap),
    .irq_en(irq_en), .match_clr(match_clr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .busy(busy), .match_flag(match_flag),
    .irq(irq), .last_status(last_status)
  );

  // {size, or_mode, mask, match, data, expected hit, expected last_status}
  localparam int NV = 9;
  localparam logic [131:0] VEC [NV] = '{
    {2'd3, 1'b0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, 1'b1, 32'h1234_5678},
    {2'd3, 1'b0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5679, 1'b0, 32'h1234_5679},
    {2'd0, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFAB, 1'b0, 32'h0000_00AB},
    {2'd0, 1'b0, 32'hFFFF_FF01, 32'h1234_5601, 32'h0000_0003, 1'b1, 32'h0000_0003},
    {2'd1, 1'b1, 32'h0000_F000, 32'h0000_F000, 32'h0000_1000, 1'b1, 32'h0000_1000},
    {2'd1, 1'b1, 32'h0000_F000, 32'h0000_F000, 32'h0000_0000, 1'b0, 32'h0000_0000},
    {2'd1, 1'b1, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000},
    {2'd2, 1'b0, 32'h00FF_0000, 32'h0080_0000, 32'hAA80_1234, 1'b1, 32'h0080_1234},
    {2'd0, 1'b0, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0055, 1'b1, 32'h0000_0055}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic kick();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_abort();
    abort = 1'b1; @(negedge clk); abort = 1'b0;
  endtask

  task automatic pulse_clr();
    match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
  endtask

  // serve one request; returns at the falling edge after the response handshake
  task automatic serve(input logic [31:0] d, input bit clr_too);
    while (!rd_req_valid) @(negedge clk);
    rd_req_ready = 1'b1; @(negedge clk); rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b1; rd_rsp_data = d; match_clr = clr_too;
    @(negedge clk);
    rd_rsp_valid = 1'b0; match_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !match_flag && !irq && !rd_req_valid && !rd_rsp_ready, "R1 idle outputs",
          {27'd0, busy, match_flag, irq, rd_req_valid, rd_rsp_ready}, 32'd0);
    check(last_status == 32'd0, "R1 last_status", last_status, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 start ignored while disabled
    kick();
    check(!busy, "R2 start ignored when disabled", {31'd0, busy}, 32'd0);
    enable = 1'b1;
    kick();
    check(busy && rd_req_valid, "R2 start raises busy and request",
          {30'd0, busy, rd_req_valid}, 32'd3);
    // R3 request held while stalled
    repeat (3) @(negedge clk);
    check(rd_req_valid && !rd_rsp_ready, "R3 request held under stall",
          {30'd0, rd_req_valid, rd_rsp_ready}, 32'd2);
    rd_req_ready = 1'b1; @(negedge clk); rd_req_ready = 1'b0;
    check(!rd_req_valid && rd_rsp_ready, "R3 response awaited after accept",
          {30'd0, rd_req_valid, rd_rsp_ready}, 32'd1);
    pulse_abort();

    // table walk: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      {cfg_size, cfg_or_mode, cfg_mask, cfg_match} = VEC[i][131:65];
      cfg_auto_stop = 1'b0; cfg_gap = 16'd0;
      pulse_clr();
      kick();
      serve(VEC[i][64:33], 1'b0);
      check(match_flag == VEC[i][32], $sformatf("R5/R6/R7 vector %0d match", i),
            {31'd0, match_flag}, {31'd0, VEC[i][32]});
      check(last_status == VEC[i][31:0], $sformatf("R4 vector %0d last_status", i),
            last_status, VEC[i][31:0]);
      pulse_abort();
    end

    // R8 gap length, gap 3 then gap 0
    cfg_size = 2'd0; cfg_or_mode = 1'b0; cfg_mask = 32'hFF; cfg_match = 32'h01;
    cfg_auto_stop = 1'b0; cfg_gap = 16'd3;
    pulse_clr();
    kick();
    serve(32'h00, 1'b0);
    n = 0;
    while (!rd_req_valid) begin n++; @(negedge clk); end
    check(n == 4, "R8 gap 3 gives 4 idle cycles", n, 32'd4);
    cfg_gap = 16'd0;
    serve(32'h00, 1'b0);
    n = 0;
    while (!rd_req_valid) begin n++; @(negedge clk); end
    check(n == 1, "R8 gap 0 gives 1 idle cycle", n, 32'd1);

    // R10 continue after match, flag sticky
    serve(32'h01, 1'b0);
    check(match_flag && busy, "R10 match keeps polling", {30'd0, match_flag, busy}, 32'd3);
    serve(32'h02, 1'b0);
    check(match_flag && busy, "R10 flag sticky after miss", {30'd0, match_flag, busy}, 32'd3);
    // R12 interrupt gating
    irq_en = 1'b1; #1;
    check(irq, "R12 irq with enable", {31'd0, irq}, 32'd1);
    irq_en = 1'b0; #1;
    check(!irq, "R12 irq gated off", {31'd0, irq}, 32'd0);
    // R11 abort keeps last_status
    pulse_abort();
    check(!busy && last_status == 32'h02, "R11 abort to idle, status kept",
          last_status, 32'h02);
    @(negedge clk);
    check(!rd_req_valid, "R11 no request after abort", {31'd0, rd_req_valid}, 32'd0);

    // R12 clear, and set winning over clear
    pulse_clr();
    check(!match_flag, "R12 clear", {31'd0, match_flag}, 32'd0);
    kick();
    serve(32'h01, 1'b1);
    check(match_flag, "R12 set wins over clear", {31'd0, match_flag}, 32'd1);
    pulse_abort();

    // R9 auto-stop
    cfg_auto_stop = 1'b1;
    pulse_clr();
    kick();
    serve(32'h00, 1'b0);
    check(busy, "R9 miss keeps polling", {31'd0, busy}, 32'd1);
    serve(32'h01, 1'b0);
    check(!busy && match_flag, "R9 stop on match", {30'd0, busy, match_flag}, 32'd1);
    repeat (3) @(negedge clk);
    check(!rd_req_valid, "R9 no further request", {31'd0, rd_req_valid}, 32'd0);

    // R11 enable falling
    kick();
    enable = 1'b0; @(negedge clk);
    check(!busy, "R11 disable forces idle", {31'd0, busy}, 32'd0);
    check(last_status == 32'h01, "R11 status kept on disable", last_status, 32'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule